// File: doc/BRIEF.md
# Horizontal vector sum reducer

This unit collapses every lane of a wide vector into a single scalar sum. The caller presents a vector together with a mode code that chooses the lane width and the signedness. It may also present a per-lane enable predicate. After a fixed latency the unit returns the sum, narrowed to the width the mode defines.

Each lane is widened before it enters the adder tree. For every mode except the 32-bit one, the sum is therefore exact. One mode gives a 16-bit saturating result: an in-range sum passes through, and an overflow is replaced by a fixed positive or negative code. With the enable bit set, only lanes whose predicate bit is set take part in the fold. A typical use is a dynamic-length sum over the first few valid lanes.

The adder tree folds pairs of partial sums, halving the count at each stage. It has one pipeline register part way down. A result appears two cycles after its input is accepted, and a new input may be accepted on every cycle.

Top module: `hsum_reducer`

## Requirements
- R1: Mode code 0 sums the VEC_W/16 16-bit lanes as signed values, sign-extended to 32 bits. The 32-bit result is exact and never saturates (32 lanes of 32767 give 1048544).
- R2: Mode code 1 sums the 16-bit lanes as unsigned values, zero-extended to 32 bits (32 lanes of 0xFFFF give 0x1FFFE0).
- R3: Mode code 2 (signed) and mode code 3 (unsigned) sum the VEC_W/8 byte lanes, each widened to 16 bits. The 16-bit sum appears in out_sum[15:0] and out_sum[31:16] is zero.
- R4: Mode code 4 sums the VEC_W/32 32-bit lanes with no widening, and the result wraps modulo 2^32.
- R5: Mode code 5 sums the 16-bit lanes as signed values. A sum in [-32768, 32767] appears unchanged in out_sum[15:0] (100, -50 and zeros give 50). A larger sum gives 0x7FFF and a smaller one gives 0x8000. In all three cases out_sum[31:16] is zero.
- R6: With in_mask_en set, in modes 0, 1 and 5, predicate bit 2i enables 16-bit lane i and bit 2i+1 has no effect. A disabled lane adds nothing.
- R7: With in_mask_en set, in modes 2 and 3, predicate bit b enables byte lane b.
- R8: With in_mask_en set, in mode 4, predicate bit 4k enables 32-bit lane k. The other three bits of each group of four have no effect.
- R9: out_valid is high exactly two cycles after each cycle in which in_valid is high. Inputs on consecutive cycles give results on consecutive cycles, in order.
- R10: While out_valid is low, out_sum holds its last value.
- R11: Mode codes 6 and 7 give a result of zero.
- R12: During reset, out_valid and out_sum are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the vector on this cycle |
| in_vec | input | VEC_W | Vector to be folded |
| in_mode | input | 3 | Lane width and signedness code |
| in_mask_en | input | 1 | Use the predicate to gate lanes |
| in_pred | input | VEC_W/8 | Lane enable predicate |
| out_valid | output | 1 | Result present on out_sum |
| out_sum | output | 32 | Reduced scalar |

## Verification
The bench builds the unit with VEC_W=128 and SPLIT_STAGE=1. This gives a three-stage tree with the pipeline register right after the first pair of adders, so both the combinational front and the combinational back of the tree carry traffic. With only eight 16-bit lanes, all eight mode codes can be crossed with masking on and off over a set of patterned and pseudo-random vectors. Sums of extreme lanes reach saturation in both directions, and the 32-bit wrap is reached in a handful of lanes.

// File: rtl/hsum_pkg.sv
`timescale 1ns/1ps
package hsum_pkg;

  // Mode codes; the numeric values are part of the interface.
  typedef enum logic [2:0] {
    MODE_S16   = 3'd0,
    MODE_U16   = 3'd1,
    MODE_S8    = 3'd2,
    MODE_U8    = 3'd3,
    MODE_W32   = 3'd4,
    MODE_SAT16 = 3'd5
  } sum_mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadPipe;  // capture the mid-tree partial sums and the mode
    logic loadOut;   // capture the shaped result
  } hsum_strobe_t;

endpackage

// File: rtl/hsum_ctrl.sv
`timescale 1ns/1ps
module hsum_ctrl
  import hsum_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output hsum_strobe_t strobe,
  output logic         outValid
);

  logic midValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      midValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      midValid <= inValid;
      outValid <= midValid;
    end
  end

  assign strobe.loadPipe = inValid;
  assign strobe.loadOut  = midValid;

endmodule

// File: rtl/hsum_datapath.sv
`timescale 1ns/1ps
module hsum_datapath
  import hsum_pkg::*;
#(
  parameter int VEC_W       = 512,
  parameter int SPLIT_STAGE = 3,
  localparam int PRED_W     = VEC_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hsum_strobe_t      strobe,
  input  logic [VEC_W-1:0]  vecIn,
  input  logic [2:0]        modeIn,
  input  logic              maskEn,
  input  logic [PRED_W-1:0] predIn,
  output logic [31:0]       sumOut
);

  localparam int N16    = VEC_W / 16;
  localparam int STAGES = $clog2(N16);
  localparam int SPLIT  = (SPLIT_STAGE < 1) ? 1 :
                          ((SPLIT_STAGE > STAGES) ? STAGES : SPLIT_STAGE);

  logic [2:0]  modeHeld;
  logic [31:0] rootSum;
  logic [31:0] shaped;

  // Level 0 holds one widened term per 16-bit slot; level s holds N16>>s partial sums.
  for (genvar s = 0; s <= STAGES; s++) begin : g_lvl
    localparam int CNT = N16 >> s;
    logic [CNT-1:0][31:0] val;

    if (s == 0) begin : g_leaf
      for (genvar i = 0; i < N16; i++) begin : g_slot
        logic [15:0] half;
        logic [7:0]  loByte;
        logic [7:0]  hiByte;
        logic [31:0] word;
        logic        enHalf;
        logic        enHi;
        logic        enWord;
        logic [31:0] term;

        assign half   = vecIn[16*i +: 16];
        assign loByte = vecIn[16*i +: 8];
        assign hiByte = vecIn[16*i+8 +: 8];
        assign word   = vecIn[32*(i/2) +: 32];
        assign enHalf = !maskEn || predIn[2*i];
        assign enHi   = !maskEn || predIn[2*i+1];
        assign enWord = !maskEn || predIn[4*(i/2)];

        always_comb begin
          case (modeIn)
            MODE_S16, MODE_SAT16:
              term = enHalf ? {{16{half[15]}}, half} : 32'd0;
            MODE_U16:
              term = enHalf ? {16'd0, half} : 32'd0;
            MODE_S8:
              term = (enHalf ? {{24{loByte[7]}}, loByte} : 32'd0)
                   + (enHi   ? {{24{hiByte[7]}}, hiByte} : 32'd0);
            MODE_U8:
              term = (enHalf ? {24'd0, loByte} : 32'd0)
                   + (enHi   ? {24'd0, hiByte} : 32'd0);
            MODE_W32:
              term = (((i % 2) == 0) && enWord) ? word : 32'd0;
            default:
              term = 32'd0;
          endcase
        end

        assign val[i] = term;
      end
    end else begin : g_sum
      for (genvar j = 0; j < CNT; j++) begin : g_pair
        logic [31:0] pairSum;
        assign pairSum = g_lvl[s-1].val[2*j] + g_lvl[s-1].val[2*j+1];

        if (s == SPLIT) begin : g_reg
          logic [31:0] held;
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               held <= 32'd0;
            else if (strobe.loadPipe) held <= pairSum;
          end
          assign val[j] = held;
        end else begin : g_comb
          assign val[j] = pairSum;
        end
      end
    end
  end

  assign rootSum = g_lvl[STAGES].val[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               modeHeld <= 3'd0;
    else if (strobe.loadPipe) modeHeld <= modeIn;
  end

  always_comb begin
    case (modeHeld)
      MODE_S16, MODE_U16, MODE_W32:
        shaped = rootSum;
      MODE_S8, MODE_U8:
        shaped = {16'd0, rootSum[15:0]};
      MODE_SAT16: begin
        if ($signed(rootSum) > 32'sd32767)       shaped = 32'h0000_7FFF;
        else if ($signed(rootSum) < -32'sd32768) shaped = 32'h0000_8000;
        else                                     shaped = {16'd0, rootSum[15:0]};
      end
      default:
        shaped = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sumOut <= 32'd0;
    else if (strobe.loadOut) sumOut <= shaped;
  end

endmodule

// File: rtl/hsum_reducer.sv
`timescale 1ns/1ps
module hsum_reducer
  import hsum_pkg::*;
#(
  parameter int VEC_W       = 512,
  parameter int SPLIT_STAGE = 3,
  localparam int PRED_W     = VEC_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_vec,
  input  logic [2:0]        in_mode,
  input  logic              in_mask_en,
  input  logic [PRED_W-1:0] in_pred,
  output logic              out_valid,
  output logic [31:0]       out_sum
);

  hsum_strobe_t strobe;

  hsum_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (in_valid),
    .strobe   (strobe),
    .outValid (out_valid)
  );

  hsum_datapath #(
    .VEC_W       (VEC_W),
    .SPLIT_STAGE (SPLIT_STAGE)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .vecIn  (in_vec),
    .modeIn (in_mode),
    .maskEn (in_mask_en),
    .predIn (in_pred),
    .sumOut (out_sum)
  );

endmodule

// File: rtl/hsum_checker.sv
`timescale 1ns/1ps
module hsum_checker
  import hsum_pkg::*;
#(
  parameter int VEC_W       = 512,
  parameter int SPLIT_STAGE = 3,
  localparam int PRED_W     = VEC_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [VEC_W-1:0]  in_vec,
  input logic [2:0]        in_mode,
  input logic              in_mask_en,
  input logic [PRED_W-1:0] in_pred,
  input logic              out_valid,
  input logic [31:0]       out_sum
);

  // Edges since reset release, saturating; guards every look into the past.
  logic [1:0] sinceRst;
  logic       histOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign histOk = (sinceRst == 2'd3);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (histOk && out_valid) |-> $past(in_valid, 2));

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (histOk && !out_valid) |-> $stable(out_sum));

  // R3
  narrow_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (histOk && out_valid && ($past(in_mode, 2) == MODE_S8 || $past(in_mode, 2) == MODE_U8))
      |-> (out_sum[31:16] == 16'd0));

  // R5
  sat_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (histOk && out_valid && $past(in_mode, 2) == MODE_SAT16) |-> (out_sum[31:16] == 16'd0));

  // R11
  reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (histOk && out_valid && $past(in_mode, 2) > MODE_SAT16) |-> (out_sum == 32'd0));

  // R6
  pred_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (histOk && out_valid && $past(in_mask_en, 2) && $past(in_pred, 2) == '0)
      |-> (out_sum == 32'd0));

  // R1
  zero_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (histOk && out_valid && $past(in_vec, 2) == '0) |-> (out_sum == 32'd0));

endmodule

bind hsum_reducer hsum_checker #(
  .VEC_W       (VEC_W),
  .SPLIT_STAGE (SPLIT_STAGE)
) u_chk (.*);

// File: tb/sim_hsum_reducer.sv
`timescale 1ns/1ps
module sim_hsum_reducer;

  localparam int VEC_W  = 128;
  localparam int PRED_W = VEC_W / 8;
  localparam int N16    = VEC_W / 16;
  localparam int N8     = VEC_W / 8;
  localparam int N32    = VEC_W / 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [VEC_W-1:0]  in_vec = '0;
  logic [2:0]        in_mode = 3'd0;
  logic              in_mask_en = 1'b0;
  logic [PRED_W-1:0] in_pred = '0;
  logic              out_valid;
  logic [31:0]       out_sum;

  int checks = 0;
  int failures = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  hsum_reducer #(.VEC_W(VEC_W), .SPLIT_STAGE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .in_mode(in_mode), .in_mask_en(in_mask_en), .in_pred(in_pred),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  function automatic logic [31:0] model(input logic [VEC_W-1:0] v, input logic [2:0] m,
                                        input logic men, input logic [PRED_W-1:0] pr);
    longint acc = 0;
    case (m)
      3'd0, 3'd5: for (int i = 0; i < N16; i++) if (!men || pr[2*i]) acc = acc + $signed(v[16*i +: 16]);
      3'd1:       for (int i = 0; i < N16; i++) if (!men || pr[2*i]) acc = acc + longint'(v[16*i +: 16]);
      3'd2:       for (int b = 0; b < N8; b++)  if (!men || pr[b])   acc = acc + $signed(v[8*b +: 8]);
      3'd3:       for (int b = 0; b < N8; b++)  if (!men || pr[b])   acc = acc + longint'(v[8*b +: 8]);
      3'd4:       for (int k = 0; k < N32; k++) if (!men || pr[4*k]) acc = acc + longint'(v[32*k +: 32]);
      default:    acc = 0;
    endcase
    case (m)
      3'd0, 3'd1, 3'd4: return acc[31:0];
      3'd2, 3'd3:       return {16'd0, acc[15:0]};
      3'd5: begin
        if (acc > 32767)       return 32'h0000_7FFF;
        else if (acc < -32768) return 32'h0000_8000;
        else                   return {16'd0, acc[15:0]};
      end
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] m, input logic men);
    if (m > 3'd5) return "R11";
    if (men) begin
      if (m == 3'd2 || m == 3'd3) return "R7";
      if (m == 3'd4)              return "R8";
      return "R6";
    end
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic run_one(input logic [VEC_W-1:0] v, input logic [2:0] m,
                         input logic men, input logic [PRED_W-1:0] pr);
    logic [31:0] exp;
    logic [31:0] held;
    exp = model(v, m, men, pr);
    @(negedge clk);
    in_valid = 1'b1; in_vec = v; in_mode = m; in_mask_en = men; in_pred = pr;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 out_valid two cycles later", {31'd0, out_valid}, 32'd1);
    check(tag(m, men), out_sum, exp);
    held = out_sum;
    @(negedge clk);
    // R10: output holds once the valid pulse has passed
    check("R10 hold", {31'd0, out_valid, held[30:0]} ^ {1'b0, out_sum[30:0]} ^ {32'd0}, {32'd0});
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VEC_W-1:0] v;
    logic [PRED_W-1:0] pr;
    logic [VEC_W-1:0] va, vb, vc;

    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R12 out_sum in reset", out_sum, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 out_valid after reset", {31'd0, out_valid}, 32'd0);

    for (int m = 0; m < 8; m++) begin
      for (int men = 0; men < 2; men++) begin
        for (int p = 0; p < 30; p++) begin
          case (p)
            0: v = '0;
            1: v = '1;
            2: v = {N16{16'h7FFF}};
            3: v = {N16{16'h8000}};
            4: v = {N8{8'h7F}};
            5: v = {N8{8'h80}};
            6: v = {N32{32'h7FFF_FFFF}};
            7: v = {N32{32'h8000_0000}};
            8: v = {{(N16-2){16'h0000}}, 16'hFFCE, 16'h0064};
            9: v = {{(N16-2){16'h0000}}, 16'h0001, 16'hFFFF};
            default: begin
              for (int w = 0; w < N32; w++) begin
                step_rng();
                v[32*w +: 32] = rng;
              end
            end
          endcase
          step_rng();
          case (p % 4)
            0: pr = '1;
            1: pr = {(PRED_W/2){2'b01}};
            2: pr = {(PRED_W/2){2'b10}};
            default: pr = rng[PRED_W-1:0];
          endcase
          run_one(v, 3'(m), 1'(men), pr);
        end
      end
    end

    // R9: back-to-back inputs produce results on consecutive cycles, in order
    va = {N16{16'h0003}}; vb = {N16{16'hFFFE}}; vc = {N16{16'h1000}};
    @(negedge clk);
    in_valid = 1'b1; in_mask_en = 1'b0; in_mode = 3'd0; in_vec = va;
    @(negedge clk);
    in_mode = 3'd1; in_vec = vb;
    @(negedge clk);
    check("R9 back-to-back first valid", {31'd0, out_valid}, 32'd1);
    check("R9 back-to-back first", out_sum, model(va, 3'd0, 1'b0, '0));
    in_mode = 3'd5; in_vec = vc;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 back-to-back second valid", {31'd0, out_valid}, 32'd1);
    check("R9 back-to-back second", out_sum, model(vb, 3'd1, 1'b0, '0));
    @(negedge clk);
    check("R9 back-to-back third valid", {31'd0, out_valid}, 32'd1);
    check("R5 back-to-back third", out_sum, 32'h0000_7FFF);
    @(negedge clk);
    check("R9 pulse ends", {31'd0, out_valid}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule